// File: doc/BRIEF.md
# Bit-Addressed Serial I/O Bus Controller

This block gives a 16-bit processor a path to peripheral bits that is apart from its memory bus. Each request names a starting bit address, a bit count and a direction. The block then walks the bus one bit per clock. For each step it drives a bit address and either an output-bit strobe with one data bit or an input-sample strobe. The address rises by one on each step, and data moves least significant bit first. Longer transfers therefore take proportionally more cycles.

The peripheral side is built in. Three small ports of 5, 7 and 4 bits each watch the strobes and decode the bit address. Each owns its own bits of a 16-bit store, which is the same size as two byte-wide latches. A single-bit test request reads one addressed bit and returns it as a flag.

Top module: `bitio_bus`

## Requirements
- R1: While reset is held and after it is released, busy, done, rdata, test_flag, port_q and both strobes are 0.
- R2: A request is taken when req_valid is high and busy is low. busy is then high for exactly N cycles, where N is req_count and the code 0 means 16. done is high for one cycle, in the first cycle after busy falls.
- R3: In step i (0-based) of a transfer, bus_addr equals req_base + i modulo 4096.
- R4: In a write (req_write=1), bus_wstb is high and bus_rstb is low in every step. bus_wbit in step i is bit i of req_wdata. Bits of req_wdata at or above N are never sent, so a transfer of 8 bits or fewer uses only the low byte.
- R5: In a read (req_write=0), bus_rstb is high and bus_wstb is low in every step. When done is high, rdata bit i holds the bit read at req_base+i, and bits N..15 are 0. rdata then holds its value until the next request is taken.
- R6: Port A decodes bit addresses 0..4 and is stored in port_q[4:0]. Port B decodes 8..14 and is stored in port_q[11:5]. Port C decodes 16..19 and is stored in port_q[15:12]. In each port, the lowest address maps to the lowest stored bit. A write step sets only the decoded bit, and a write to any other address changes nothing.
- R7: A read step at an address that no port decodes returns 0.
- R8: A test request (req_test=1) always moves one bit, regardless of req_count and req_write. When done is high, test_flag and rdata[0] hold the addressed bit.
- R9: A request raised while busy is high is ignored. It causes no extra busy cycle and no change in port_q.
- R10: test_flag changes only when a test request completes. Reads and writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = output bits, 0 = input bits |
| req_test | input | 1 | Single-bit test request |
| req_count | input | 4 | Bit count, 0 encodes 16 |
| req_base | input | 12 | First bit address |
| req_wdata | input | 16 | Data to send, LSB first |
| busy | output | 1 | High while bits are moving |
| done | output | 1 | One-cycle pulse after the last bit |
| rdata | output | 16 | Collected input bits |
| test_flag | output | 1 | Result of the last test request |
| bus_addr | output | 12 | Current bit address |
| bus_wstb | output | 1 | Output-bit strobe |
| bus_wbit | output | 1 | Output bit value |
| bus_rstb | output | 1 | Input-sample strobe |
| port_q | output | 16 | Stored bits of ports A, B and C |

## Verification
The in-line properties check several things on every cycle:
- the bit address climbs by one per step, including across the wrap at 4095;
- done follows only the falling edge of busy;
- the port decoders never overlap, and undecoded reads return zero;
- a port's stored bits move only under its own write strobe;
- the flag and the read word stay frozen outside their update points.

Only the bench's scenarios can show that whole words land in the right packed port bits, that transfer length follows the count code (including 0 as 16), that a test request ignores its count, and that a request raised mid-transfer leaves no trace.

// File: rtl/bitio_pkg.sv
package bitio_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = $clog2(DATA_W);
  localparam int unsigned NPORTS = 3;

  localparam int unsigned PORT_BASE  [NPORTS] = '{0, 8, 16};
  localparam int unsigned PORT_WIDTH [NPORTS] = '{5, 7, 4};

  // Packed position of a port inside the shared store
  function automatic int unsigned port_offset(input int unsigned p);
    int unsigned sum;
    sum = 0;
    for (int unsigned k = 0; k < p; k++) sum += PORT_WIDTH[k];
    return sum;
  endfunction

  function automatic int unsigned store_width();
    return port_offset(NPORTS);
  endfunction

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

endpackage

// File: rtl/bitio_rst_sync.sv
module bitio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/bitio_port.sv
module bitio_port #(
  parameter int unsigned AW    = 12,
  parameter int unsigned BASE  = 0,
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wstb,
  input  logic             wbit,
  output logic             hit,
  output logic             rbit,
  output logic [WIDTH-1:0] q
);

  localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + WIDTH);

  logic [IW-1:0]    bit_sel;
  logic             wr_en;
  logic [WIDTH-1:0] q_d;
  logic [WIDTH-1:0] q_q;

  assign hit     = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
  assign bit_sel = IW'(addr - LO[AW-1:0]);
  assign wr_en   = wstb & hit;

  always_comb begin
    q_d = q_q;
    if (wr_en) q_d[bit_sel] = wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (wr_en) begin
      q_q <= q_d;
    end
  end

  assign rbit = hit ? q_q[bit_sel] : 1'b0;
  assign q    = q_q;

  AST_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wstb && hit) |=> $stable(q_q)) else $error("port bits moved without a strobe"); // R6

endmodule

// File: rtl/bitio_seq.sv
module bitio_seq
  import bitio_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_test,
  input  logic [CW-1:0] req_count,
  input  logic [AW-1:0] req_base,
  input  logic [DW-1:0] req_wdata,
  input  logic          bus_rbit,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          test_flag,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wstb,
  output logic          bus_wbit,
  output logic          bus_rstb
);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] base_q,  base_d;
  logic [CW-1:0] last_q,  last_d;
  logic [CW-1:0] idx_q,   idx_d;
  logic          wr_q,    wr_d;
  logic          tst_q,   tst_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          flag_q,  flag_d;
  logic          done_q,  done_d;
  logic          step_last;
  logic          seq_en;

  assign step_last = (idx_q == last_q);
  assign seq_en    = (state_q == ST_RUN) || req_valid;

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    last_d  = last_q;
    idx_d   = idx_q;
    wr_d    = wr_q;
    tst_d   = tst_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    flag_d  = flag_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_RUN;
          base_d  = req_base;
          idx_d   = '0;
          tst_d   = req_test;
          wr_d    = req_write & ~req_test;
          last_d  = req_test ? '0 : (req_count - 1'b1);
          wdata_d = req_wdata;
          rdata_d = '0;
        end
      end
      ST_RUN: begin
        if (!wr_q) rdata_d[idx_q] = bus_rbit;
        if (step_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (tst_q) flag_d = bus_rbit;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      last_q  <= '0;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      tst_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      flag_q  <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_d;
      base_q  <= base_d;
      last_q  <= last_d;
      idx_q   <= idx_d;
      wr_q    <= wr_d;
      tst_q   <= tst_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      flag_q  <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign busy      = (state_q == ST_RUN);
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign test_flag = flag_q;
  assign bus_addr  = base_q + {{(AW-CW){1'b0}}, idx_q};
  assign bus_wstb  = busy & wr_q;
  assign bus_rstb  = busy & ~wr_q;
  assign bus_wbit  = wdata_q[idx_q];

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_last) |=> (busy && bus_addr == $past(bus_addr) + 1'b1)) else $error("address did not advance"); // R3

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))) else $error("done without preceding transfer"); // R2

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(test_flag)) else $error("flag moved outside completion"); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> $stable(rdata)) else $error("read word moved while idle"); // R5

endmodule

// File: rtl/bitio_bus.sv
module bitio_bus
  import bitio_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CNT_W,
  parameter int unsigned NP = NPORTS,
  parameter int unsigned SW = store_width()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_test,
  input  logic [CW-1:0] req_count,
  input  logic [AW-1:0] req_base,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          test_flag,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wstb,
  output logic          bus_wbit,
  output logic          bus_rstb,
  output logic [SW-1:0] port_q
);

  logic          rst_sync_n;
  logic [NP-1:0] hits;
  logic [NP-1:0] rbits;
  logic          bus_rbit;

  bitio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bitio_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_test  (req_test),
    .req_count (req_count),
    .req_base  (req_base),
    .req_wdata (req_wdata),
    .bus_rbit  (bus_rbit),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .test_flag (test_flag),
    .bus_addr  (bus_addr),
    .bus_wstb  (bus_wstb),
    .bus_wbit  (bus_wbit),
    .bus_rstb  (bus_rstb)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    bitio_port #(
      .AW    (AW),
      .BASE  (PORT_BASE[p]),
      .WIDTH (PORT_WIDTH[p])
    ) u_port (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .addr  (bus_addr),
      .wstb  (bus_wstb),
      .wbit  (bus_wbit),
      .hit   (hits[p]),
      .rbit  (rbits[p]),
      .q     (port_q[port_offset(p) +: PORT_WIDTH[p]])
    );
  end

  assign bus_rbit = |rbits;

  AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(hits)) else $error("two ports decode one address"); // R6

  AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rstb && hits == '0) |-> !bus_rbit) else $error("undecoded read not zero"); // R7

endmodule

// File: tb/bitio_bus_tb.sv
module bitio_bus_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic        req_test;
  logic [3:0]  req_count;
  logic [11:0] req_base;
  logic [15:0] req_wdata;
  logic        busy;
  logic        done;
  logic [15:0] rdata;
  logic        test_flag;
  logic [11:0] bus_addr;
  logic        bus_wstb;
  logic        bus_wbit;
  logic        bus_rstb;
  logic [15:0] port_q;

  int  n_checks;
  int  n_bad;
  bit  finished;

  logic [15:0] mq;
  logic        mflag;

  bitio_bus u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_test(req_test), .req_count(req_count), .req_base(req_base),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .test_flag(test_flag), .bus_addr(bus_addr), .bus_wstb(bus_wstb),
    .bus_wbit(bus_wbit), .bus_rstb(bus_rstb), .port_q(port_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {test, write, count, base, wdata}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd0,  12'd0,    16'hA5C3},
    {1'b0, 1'b0, 4'd0,  12'd0,    16'h0000},
    {1'b0, 1'b1, 4'd4,  12'd16,   16'h000B},
    {1'b0, 1'b0, 4'd8,  12'd14,   16'h0000},
    {1'b1, 1'b0, 4'd1,  12'd2,    16'h0000},
    {1'b0, 1'b1, 4'd5,  12'd0,    16'hFFE0},
    {1'b1, 1'b0, 4'd1,  12'd2,    16'h0000},
    {1'b0, 1'b1, 4'd0,  12'd4,    16'h1234},
    {1'b0, 1'b0, 4'd0,  12'd4,    16'h0000},
    {1'b0, 1'b1, 4'd3,  12'd100,  16'h0007},
    {1'b0, 1'b0, 4'd3,  12'd100,  16'h0000},
    {1'b0, 1'b1, 4'd3,  12'd4095, 16'h0005},
    {1'b0, 1'b0, 4'd12, 12'd8,    16'h0000},
    {1'b1, 1'b1, 4'd5,  12'd9,    16'h0000}
  };

  function automatic int map_bit(input int a);
    if (a >= 0  && a <= 4)  return a;
    if (a >= 8  && a <= 14) return a - 8 + 5;
    if (a >= 16 && a <= 19) return a - 16 + 12;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit tst, input bit wr, input logic [3:0] cnt,
                        input logic [11:0] base, input logic [15:0] wd, input bit inj);
    int n;
    int errs_t, errs_a, errs_s;
    logic [15:0] exp_rd;
    logic [11:0] a;
    int m;
    n = tst ? 1 : ((cnt == 4'd0) ? 16 : int'(cnt));
    errs_t = 0; errs_a = 0; errs_s = 0;
    exp_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_test = tst; req_write = wr;
    req_count = cnt; req_base = base; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      a = base + 12'(i);
      m = map_bit(int'(a));
      if (!busy || done) errs_t++;
      if (bus_addr !== a) errs_a++;
      if (wr && !tst) begin
        if (!bus_wstb || bus_rstb || bus_wbit !== wd[i]) errs_s++;
        if (m >= 0) mq[m] = wd[i];
      end else begin
        if (!bus_rstb || bus_wstb) errs_s++;
        exp_rd[i] = (m >= 0) ? mq[m] : 1'b0;
      end
      if (inj && i == 2) begin
        req_valid = 1'b1; req_test = 1'b0; req_write = 1'b1;
        req_count = 4'd4; req_base = 12'd16; req_wdata = 16'h000F;
      end
      if (inj && i == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (tst) mflag = exp_rd[0];
    chk(errs_t == 0 && !busy && done, "R2 busy length/done", 32'(errs_t), 32'd0);
    chk(errs_a == 0, "R3 address sequence", 32'(errs_a), 32'd0);
    if (wr && !tst) chk(errs_s == 0, "R4 write strobes/bits", 32'(errs_s), 32'd0);
    else            chk(errs_s == 0, "R5 read strobes", 32'(errs_s), 32'd0);
    chk(rdata === exp_rd, tst ? "R8 test rdata" : "R5 R7 rdata", 32'(rdata), 32'(exp_rd));
    chk(port_q === mq, "R6 port store", 32'(port_q), 32'(mq));
    chk(test_flag === mflag, tst ? "R8 test flag" : "R10 flag hold", 32'(test_flag), 32'(mflag));
    @(negedge clk);
    chk(!done && !busy, inj ? "R9 no extra transfer" : "R2 done single pulse",
        {30'd0, busy, done}, 32'd0);
    if (inj) begin
      @(negedge clk);
      chk(!busy && port_q === mq, "R9 ignored request left store", 32'(port_q), 32'(mq));
    end
  endtask

  initial begin
    n_checks = 0; n_bad = 0; finished = 1'b0;
    mq = '0; mflag = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_test = 1'b0;
    req_count = '0; req_base = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && rdata == 16'd0 && !test_flag && port_q == 16'd0 && !bus_wstb && !bus_rstb,
        "R1 reset held", {busy, done, test_flag, bus_wstb, bus_rstb, 11'd0, port_q | rdata}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && rdata == 16'd0 && !test_flag && port_q == 16'd0 && !bus_wstb && !bus_rstb,
        "R1 after release", {busy, done, test_flag, bus_wstb, bus_rstb, 11'd0, port_q | rdata}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][33], VEC[v][32], VEC[v][31:28], VEC[v][27:16], VEC[v][15:0], 1'b0);
    end

    // request during a transfer must vanish
    run_op(1'b0, 1'b1, 4'd8, 12'd8, 16'h005A, 1'b1);
    run_op(1'b0, 1'b0, 4'd4, 12'd16, 16'h0000, 1'b0);

    // reset in the middle of a state-bearing run
    rst_n = 1'b0;
    @(negedge clk);
    chk(port_q == 16'd0 && !busy && !test_flag, "R1 reset clears store",
        32'(port_q), 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule